// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block loads a configuration bitstream into a target FPGA through its one-bit serial configuration port. A local source hands it bitstream bytes on a valid/ready input. A pulse on `start_i` makes the block put the target into reset: it drives the active-low program line and waits for the target's open-drain init line to fall. It then releases the program line and waits for init to clear. After that it shifts every byte out on the data line, most significant bit first, and generates the configuration clock from the system clock.

Before each byte it checks the init and done inputs for a CRC failure. After the byte flagged as last it holds the data line high and keeps toggling the configuration clock until the target raises done. A timeout bounds every wait. The outcome is given as `done_ok_o` or as `error_o` with a 2-bit cause. The outcome stays on the outputs until the next start.

Top module: `serial_cfg_loader`

## Requirements
- R1: A `start_i` pulse while `busy_o` is low makes `busy_o` rise and `prog_no` fall one clock later, and clears `done_ok_o`, `error_o` and `err_code_o`. A `start_i` pulse while `busy_o` is high has no effect.
- R2: `prog_no` stays low until `init_ni` is sampled low, and rises on the next clock. If `init_ni` is not seen low within WAIT_CYCLES clocks, the load ends with `error_o` and `err_code_o` = 0 (init-fall timeout).
- R3: After `prog_no` is released, no byte is accepted and no configuration clock edge is made until `init_ni` is sampled high. If that does not happen within WAIT_CYCLES clocks, the load ends with `err_code_o` = 1 (init-clear timeout).
- R4: Each byte is sent MSB first as 8 bits. For each bit, `cclk_o` is low for HALF_PERIOD clocks with the bit already on `din_o`, then high for HALF_PERIOD clocks while `din_o` is stable.
- R5: `byte_ready_o` is high only in the state that waits for a byte, which comes after the previous byte's bit 0 is complete. A byte is taken in the cycle where ready and valid are both high. `byte_last_i` marks the final byte.
- R6: Before each byte, if `done_i` is low and `init_ni` is low, the load stops with `err_code_o` = 2 (CRC error).
- R7: After the final byte, `din_o` stays high and `cclk_o` toggles with half-period HALF_PERIOD. When `done_i` is sampled high, `done_ok_o` rises and `busy_o` falls on the next clock.
- R8: If `done_i` does not rise within WAIT_CYCLES clocks after the final byte, the load ends with `err_code_o` = 3 (done timeout).
- R9: At most one of `busy_o`, `done_ok_o` and `error_o` is high. `done_ok_o`, `error_o` and `err_code_o` hold their values until the next accepted start.
- R10: While reset is asserted and after it ends, `prog_no` is 1, `cclk_o` is 0, `din_o` is 1, and `byte_ready_o`, `busy_o`, `done_ok_o` and `error_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a load |
| byte_valid_i | input | 1 | Bitstream byte is valid |
| byte_data_i | input | 8 | Bitstream byte |
| byte_last_i | input | 1 | Marks the final byte of the bitstream |
| byte_ready_o | output | 1 | Block takes a byte this cycle if valid is high |
| prog_no | output | 1 | Active-low program/reset line to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data |
| init_ni | input | 1 | Target init line, low while the target resets or on a CRC failure |
| done_i | input | 1 | Target done line |
| busy_o | output | 1 | Load in progress |
| done_ok_o | output | 1 | Last load succeeded |
| error_o | output | 1 | Last load failed |
| err_code_o | output | 2 | Failure cause: 0 init fall, 1 init clear, 2 CRC, 3 done timeout |

## Verification
Every output is decoded from registered state, so a wrong state appears at the ports on the clock edge where the state goes wrong. A wrong configuration-clock phase, a wrong bit on the data line, or a ready held at the wrong time therefore differs from the cycle-level reference within one cycle. A wrong bit index or byte order is also caught when the bits the target samples on each rising clock edge are rebuilt into bytes and compared. Timeout faults show as a status that is early or late by a known number of cycles. The reset, init-clear, CRC and done failures are each forced in their own run.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_CLR, ST_CHECK, ST_BYTE,
    ST_LO, ST_HI, ST_FL_LO, ST_FL_HI, ST_OK, ST_FAIL
  } ld_state_e;

  typedef enum logic [1:0] {
    EC_INIT_FALL = 2'd0,
    EC_INIT_CLR  = 2'd1,
    EC_CRC       = 2'd2,
    EC_DONE      = 2'd3
  } ld_err_e;
endpackage

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
  parameter int LIMIT = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (en_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LAST);
endmodule

// File: rtl/cfg_ld_pace.sv
module cfg_ld_pace #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF - 1);

  logic [HW-1:0] hc_q;

  assign tick_o = (hc_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hc_q <= '0;
    else if (clr_i)  hc_q <= '0;
    else if (tick_o) hc_q <= '0;
    else             hc_q <= hc_q + 1'b1;
  end
endmodule

// File: rtl/cfg_ld_shift.sv
module cfg_ld_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic         shift_i,
  output logic         msb_o,
  output logic         final_o,
  output logic         last_o
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh_q;
  logic [BW-1:0] idx_q;
  logic          last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= data_i;
      idx_q  <= '0;
      last_q <= last_i;
    end else if (shift_i) begin
      sh_q   <= {sh_q[W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign msb_o   = sh_q[W-1];
  assign final_o = (idx_q == BW'(W - 1));
  assign last_o  = last_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_ld_pkg::*;
#(
  parameter int HALF_PERIOD = 2,
  parameter int WAIT_CYCLES = 1000000,
  parameter int BYTE_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  output logic              prog_no,
  output logic              cclk_o,
  output logic              din_o,
  input  logic              init_ni,
  input  logic              done_i,
  output logic              busy_o,
  output logic              done_ok_o,
  output logic              error_o,
  output logic [1:0]        err_code_o
);
  ld_state_e st_q, st_d;
  ld_err_e   code_q, code_d;
  logic tmr_clr, tmr_en, tmr_exp;
  logic pace_clr, tick;
  logic byte_load, bit_shift;
  logic sh_msb, sh_final, sh_last;

  cfg_ld_timer #(.LIMIT(WAIT_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .en_i(tmr_en), .expired_o(tmr_exp)
  );

  cfg_ld_pace #(.HALF(HALF_PERIOD)) u_pace (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pace_clr), .tick_o(tick)
  );

  cfg_ld_shift #(.W(BYTE_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(byte_load), .data_i(byte_data_i),
    .last_i(byte_last_i), .shift_i(bit_shift), .msb_o(sh_msb),
    .final_o(sh_final), .last_o(sh_last)
  );

  assign tmr_en = (st_q == ST_PROG) || (st_q == ST_CLR) ||
                  (st_q == ST_FL_LO) || (st_q == ST_FL_HI);

  always_comb begin
    st_d      = st_q;
    code_d    = code_q;
    tmr_clr   = 1'b0;
    pace_clr  = 1'b0;
    byte_load = 1'b0;
    bit_shift = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_OK, ST_FAIL: begin
        if (start_i) begin
          st_d    = ST_PROG;
          code_d  = EC_INIT_FALL;
          tmr_clr = 1'b1;
        end
      end
      ST_PROG: begin
        if (!init_ni) begin
          st_d    = ST_CLR;
          tmr_clr = 1'b1;
        end else if (tmr_exp) begin
          st_d   = ST_FAIL;
          code_d = EC_INIT_FALL;
        end
      end
      ST_CLR: begin
        if (init_ni) st_d = ST_CHECK;
        else if (tmr_exp) begin
          st_d   = ST_FAIL;
          code_d = EC_INIT_CLR;
        end
      end
      ST_CHECK: begin
        if (!done_i && !init_ni) begin
          st_d   = ST_FAIL;
          code_d = EC_CRC;
        end else st_d = ST_BYTE;
      end
      ST_BYTE: begin
        if (byte_valid_i) begin
          byte_load = 1'b1;
          pace_clr  = 1'b1;
          st_d      = ST_LO;
        end
      end
      ST_LO: if (tick) st_d = ST_HI;
      ST_HI: begin
        if (tick) begin
          if (sh_final) begin
            st_d    = sh_last ? ST_FL_LO : ST_CHECK;
            tmr_clr = sh_last;
          end else begin
            bit_shift = 1'b1;
            st_d      = ST_LO;
          end
        end
      end
      ST_FL_LO, ST_FL_HI: begin
        if (done_i) st_d = ST_OK;
        else if (tmr_exp) begin
          st_d   = ST_FAIL;
          code_d = EC_DONE;
        end else if (tick) st_d = (st_q == ST_FL_LO) ? ST_FL_HI : ST_FL_LO;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_q <= EC_INIT_FALL;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  assign prog_no      = (st_q != ST_PROG);
  assign cclk_o       = (st_q == ST_HI) || (st_q == ST_FL_HI);
  assign din_o        = ((st_q == ST_LO) || (st_q == ST_HI)) ? sh_msb : 1'b1;
  assign byte_ready_o = (st_q == ST_BYTE);
  assign busy_o       = !((st_q == ST_IDLE) || (st_q == ST_OK) || (st_q == ST_FAIL));
  assign done_ok_o    = (st_q == ST_OK);
  assign error_o      = (st_q == ST_FAIL);
  assign err_code_o   = code_q;

  AST_PROG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> (!cclk_o && !byte_ready_o && din_o)); // R2
  AST_HIGH_DIN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o)); // R4
  AST_ACCEPT_TO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ready_o && byte_valid_i) |=> (!byte_ready_o && !cclk_o && busy_o)); // R5
  AST_DONE_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_ok_o) |-> $past(done_i)); // R7
  AST_ONE_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_ok_o, error_o})); // R9
  AST_STATUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_ok_o || error_o) && !start_i) |=> $stable({done_ok_o, error_o, err_code_o})); // R9
endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb_top;
  localparam int H  = 2;
  localparam int TO = 40;

  localparam int M_IDLE = 0, M_PROG = 1, M_CLR = 2, M_CHK = 3, M_BYTE = 4,
                 M_LO = 5, M_HI = 6, M_FLO = 7, M_FHI = 8, M_OK = 9, M_FAIL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       start = 1'b0, bv = 1'b0, bl = 1'b0, init_n = 1'b1, done = 1'b0;
  logic [7:0] bd = 8'h00;
  logic       ready, prog_n, cclk, din, busy, ok, err;
  logic [1:0] code;

  serial_cfg_loader #(.HALF_PERIOD(H), .WAIT_CYCLES(TO), .BYTE_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_valid_i(bv),
    .byte_data_i(bd), .byte_last_i(bl), .byte_ready_o(ready), .prog_no(prog_n),
    .cclk_o(cclk), .din_o(din), .init_ni(init_n), .done_i(done), .busy_o(busy),
    .done_ok_o(ok), .error_o(err), .err_code_o(code)
  );

  int n_run = 0, n_fail = 0, cyc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle-level reference model
  int m_st = M_IDLE, m_t = 0, m_h = 0, m_i = 0, m_sh = 0, m_last = 0, m_code = 0;
  bit m_taken = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_t = 0; m_h = 0; m_i = 0; m_sh = 0; m_last = 0; m_code = 0; m_taken = 0;
    end else begin
      m_taken = 0;
      case (m_st)
        M_IDLE, M_OK, M_FAIL:
          if (start) begin m_st = M_PROG; m_t = 0; m_code = 0; end
        M_PROG:
          if (!init_n) begin m_st = M_CLR; m_t = 0; end
          else if (m_t == TO - 1) begin m_st = M_FAIL; m_code = 0; end
          else m_t++;
        M_CLR:
          if (init_n) m_st = M_CHK;
          else if (m_t == TO - 1) begin m_st = M_FAIL; m_code = 1; end
          else m_t++;
        M_CHK:
          if (!done && !init_n) begin m_st = M_FAIL; m_code = 2; end
          else m_st = M_BYTE;
        M_BYTE:
          if (bv) begin m_taken = 1; m_sh = int'(bd); m_last = int'(bl); m_i = 0; m_h = 0; m_st = M_LO; end
        M_LO:
          if (m_h == H - 1) begin m_h = 0; m_st = M_HI; end else m_h++;
        M_HI:
          if (m_h == H - 1) begin
            m_h = 0;
            if (m_i == 7) begin
              if (m_last != 0) begin m_st = M_FLO; m_t = 0; end else m_st = M_CHK;
            end else begin m_i++; m_st = M_LO; end
          end else m_h++;
        M_FLO, M_FHI:
          if (done) m_st = M_OK;
          else if (m_t == TO - 1) begin m_st = M_FAIL; m_code = 3; end
          else begin
            m_t++;
            if (m_h == H - 1) begin m_h = 0; m_st = (m_st == M_FLO) ? M_FHI : M_FLO; end
            else m_h++;
          end
        default: m_st = M_IDLE;
      endcase
    end
  end

  // target and source behaviour
  int tg = 0, tc = 0, rises = 0;
  int fall_dly = -1, clr_dly = -1, crc_bits = -1, done_rise = -1;
  bit gap = 0;
  logic prev_cclk = 1'b0;
  int q[$];
  int cap[$];

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
    if (rst_n) begin
      chk("R2 prog_no", prog_n, (m_st == M_PROG) ? 0 : 1);
      chk("R4 cclk", cclk, (m_st == M_HI || m_st == M_FHI) ? 1 : 0);
      chk("R4 din", din, (m_st == M_LO || m_st == M_HI) ? ((m_sh >> (7 - m_i)) & 1) : 1);
      chk("R5 ready", ready, (m_st == M_BYTE) ? 1 : 0);
      chk("R1 busy", busy, (m_st != M_IDLE && m_st != M_OK && m_st != M_FAIL) ? 1 : 0);
      chk("R7 done_ok", ok, (m_st == M_OK) ? 1 : 0);
      chk("R9 error", err, (m_st == M_FAIL) ? 1 : 0);
      if (m_st == M_FAIL) chk("R9 err_code", code, m_code);
    end
    case (tg)
      0: if (!prog_n) begin tg = 1; tc = 0; end
      1: begin
        tc++;
        if (fall_dly >= 0 && tc >= fall_dly) init_n = 1'b0;
        if (prog_n) begin tg = 2; tc = 0; end
      end
      2: begin
        tc++;
        if (clr_dly >= 0 && tc >= clr_dly) begin init_n = 1'b1; tg = 3; end
      end
      default: begin
        if (cclk && !prev_cclk) begin
          rises++;
          cap.push_back(int'(din));
          if (crc_bits >= 0 && rises == crc_bits) init_n = 1'b0;
          if (done_rise >= 0 && rises >= done_rise) done = 1'b1;
        end
      end
    endcase
    prev_cclk = cclk;
    if (m_taken && q.size() > 0) void'(q.pop_front());
    bv = (q.size() > 0) && !(gap && (cyc % 3 == 0));
    bd = (q.size() > 0) ? 8'(q[0]) : 8'h00;
    bl = (q.size() == 1);
  end

  task automatic run(input int bytes[$], input int f, input int c, input int crc,
                     input int dr, input bit g, input int poke);
    @(negedge clk);
    tg = 0; tc = 0; rises = 0; init_n = 1'b1; done = 1'b0;
    fall_dly = f; clr_dly = c; crc_bits = crc; done_rise = dr; gap = g;
    cap.delete();
    q = bytes;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (k == poke) start = 1'b1;
      else start = 1'b0;
      if (m_st == M_OK || m_st == M_FAIL) break;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_bytes(input int bytes[$], input int nb);
    for (int b = 0; b < nb; b++) begin
      int v = 0;
      for (int k = 0; k < 8; k++) v = (v << 1) | ((8 * b + k < cap.size()) ? cap[8 * b + k] : 0);
      chk("R4 byte rebuilt MSB first", v, bytes[b]);
    end
  endtask

  initial begin
    int seq_a[$] = '{8'hA5, 8'h3C, 8'h81};
    int seq_b[$] = '{8'h01, 8'hFE};
    repeat (3) @(negedge clk);
    chk("R10 prog_no in reset", prog_n, 1);
    chk("R10 cclk in reset", cclk, 0);
    chk("R10 din in reset", din, 1);
    chk("R10 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 ready after reset", ready, 0);
    chk("R10 status after reset", {ok, err}, 0);

    // normal load with an ignored start pulse mid-stream
    run(seq_a, 3, 5, -1, 28, 0, 30);
    chk("R7 load ok", ok, 1);
    chk("R1 ignored start kept load", err, 0);
    chk("R4 data bits", cap.size() >= 24, 1);
    cmp_bytes(seq_a, 3);
    for (int k = 24; k < cap.size(); k++) chk("R7 din high in flush", cap[k], 1);
    repeat (20) @(negedge clk);
    chk("R9 done_ok held", ok, 1);

    // source with gaps, short stream
    run(seq_b, 1, 2, -1, 18, 1, -1);
    chk("R5 gapped load ok", ok, 1);
    cmp_bytes(seq_b, 2);

    // init never falls
    run(seq_a, -1, 2, -1, 28, 0, -1);
    chk("R2 init-fall timeout", {err, code}, {1'b1, 2'd0});
    chk("R2 no data sent", rises, 0);

    // init never clears
    run(seq_a, 2, -1, -1, 28, 0, -1);
    chk("R3 init-clear timeout", {err, code}, {1'b1, 2'd1});
    chk("R3 no data sent", rises, 0);
    chk("R3 no byte taken", q.size(), 3);

    // CRC after first byte
    run(seq_a, 2, 3, 8, -1, 0, -1);
    chk("R6 crc error", {err, code}, {1'b1, 2'd2});
    chk("R6 stopped after one byte", rises, 8);

    // done never rises
    run(seq_b, 2, 3, -1, -1, 0, -1);
    chk("R8 done timeout", {err, code}, {1'b1, 2'd3});
    repeat (20) @(negedge clk);
    chk("R9 error held", {err, code}, {1'b1, 2'd3});

    // restart after failure clears status
    run(seq_b, 2, 3, -1, 17, 0, -1);
    chk("R1 restart after failure", {ok, err}, 2'b10);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule